// File: doc/BRIEF.md
# ATM Cell Byte Transposer and Interleaver

This block sits between a cell buffer and a SONET framer on the transmit side of an ATM line interface. Cells arrive as thirteen 32-bit words; the header check byte is not carried, so each cell brings 52 bytes. The block stores the cells, rebuilds the header check byte and scrambles the 48 payload bytes. It then hands the framer one byte for each payload byte slot the framer offers.

It runs in one of two configurations. In single-stream mode every word feeds one stream, which holds two cell buffers in ping-pong, so one cell can be loaded while the other is emitted. In quad mode there are four independent tributaries, each with its own pair of cell buffers and its own scrambler. The output takes one byte from each tributary in turn. A stream whose turn comes at a cell boundary with no complete cell ready emits an idle cell instead. The mode is a configuration input and must stay constant between resets.

Top module: `cell_byte_mux`

## Requirements
- R1: A cell is the 13 words following and including a word with `word_sop_i` high; the first stored byte of each word is bits 31:24, and the stored bytes leave in arrival order.
- R2: Every emitted cell is 53 bytes: the four stored header bytes unchanged, then a check byte equal to the CRC-8 (polynomial x^8+x^2+x+1, zero initial value, MSB first) of those four bytes XOR 0x55, then the 48 payload bytes. `byte_sop_o` is high exactly with the first header byte.
- R3: Each payload byte is scrambled MSB first by a self-synchronous x^43+1 scrambler: out = in XOR the output bit 43 bits earlier. Each stream keeps its own state, cleared by reset, and advances only on payload bytes (idle cells included).
- R4: When a stream reaches a cell boundary with no complete cell stored, it emits an idle cell: header 00 00 00 01, check byte 0x52, payload bytes 0x6A before scrambling.
- R5: With `quad_mode_i` low, all words go to stream 0 whatever `word_trib_i` holds, and every output byte has `byte_trib_o` = 0.
- R6: With `quad_mode_i` high, words go to the tributary given by `word_trib_i`, and consecutive output bytes come from tributaries 0, 1, 2, 3, 0, ... with `byte_trib_o` naming the source.
- R7: Each stream holds at most two complete cells; `space_o[t]` is high while stream t can accept a cell, and a cell started while it is low is discarded whole.
- R8: The outputs update one clock after a cycle with `slot_i` high; while `slot_i` is low, outputs and all read pointers and scrambler states hold.
- R9: After reset `byte_o`, `byte_sop_o` and `byte_trib_o` are zero and `space_o` is all ones.
- R10: A new `word_sop_i` before a cell is complete discards the partial cell; words arriving with no cell open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| quad_mode_i | input | 1 | 0: single stream, 1: four interleaved tributaries |
| word_valid_i | input | 1 | Input word present |
| word_sop_i | input | 1 | Input word is the first of a cell |
| word_trib_i | input | 2 | Tributary of the input word (quad mode) |
| word_data_i | input | 32 | Cell word, first byte in bits 31:24 |
| space_o | output | 4 | Per-stream room for another cell |
| slot_i | input | 1 | Framer offers a payload byte slot |
| byte_o | output | 8 | Output byte |
| byte_sop_o | output | 1 | Output byte is the first byte of a cell |
| byte_trib_o | output | 2 | Tributary the output byte came from |

## Verification
The assertions check on every cycle that the read position stays inside a 53-byte cell and that no stream writes into a buffer still holding a complete cell. They also check that idle slots freeze the output and that quad-mode bytes step through the tributaries in order. Only the bench scenarios can show the byte contents: the check byte, the scrambled payload, idle-cell substitution, the ping-pong order across two stored cells, and the discarding of dropped, partial or stray input.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned CELL_WORDS = 13;
  localparam int unsigned HDR_BYTES  = 4;
  localparam int unsigned SCR_LEN    = 43;
  localparam logic [7:0]  HEC_COSET  = 8'h55;
  localparam logic [31:0] IDLE_HDR   = 32'h0000_0001;
  localparam logic [7:0]  IDLE_FILL  = 8'h6A;

  function automatic logic [7:0] hec_calc(input logic [31:0] hdr);
    logic [7:0] crc;
    logic       fb;
    crc = '0;
    for (int i = 31; i >= 0; i--) begin
      fb  = crc[7] ^ hdr[i];
      crc = {crc[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return crc ^ HEC_COSET;
  endfunction

  // returns {next_state, scrambled_byte}
  function automatic logic [SCR_LEN+7:0] scr_step(input logic [SCR_LEN-1:0] st,
                                                  input logic [7:0] d);
    logic [7:0] o;
    for (int i = 7; i >= 0; i--) begin
      o[i] = d[i] ^ st[SCR_LEN-1];
      st   = {st[SCR_LEN-2:0], o[i]};
    end
    return {st, o};
  endfunction
endpackage

// File: rtl/cbm_lane.sv
module cbm_lane
  import cbm_pkg::*;
#(
  parameter int unsigned WORDS = CELL_WORDS
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sop_i,
  input  logic [31:0] wr_data_i,
  input  logic        adv_i,
  output logic [7:0]  byte_o,
  output logic        sop_o,
  output logic        space_o
);
  localparam int unsigned IN_BYTES = 4 * WORDS;
  localparam int unsigned LAST_POS = IN_BYTES;      // 53 bytes out: 0..52
  localparam int unsigned POS_W    = $clog2(LAST_POS + 1);
  localparam int unsigned CNT_W    = $clog2(WORDS);
  localparam int unsigned BIX_W    = $clog2(IN_BYTES);

  logic [31:0]        mem_q [2][WORDS];
  logic [1:0]         full_q, full_d;
  logic               wr_bank_q, wr_act_q;
  logic [CNT_W-1:0]   wr_cnt_q;
  logic               rd_bank_q, real_q;
  logic [POS_W-1:0]   pos_q;
  logic [SCR_LEN-1:0] scr_q;

  // write side
  logic wr_first, wr_more, wr_done;
  assign wr_first = wr_en_i && wr_sop_i && !full_q[wr_bank_q];
  assign wr_more  = wr_en_i && !wr_sop_i && wr_act_q;
  assign wr_done  = wr_more && (wr_cnt_q == CNT_W'(WORDS - 1));

  always_ff @(posedge clk_i) begin
    if (wr_first) mem_q[wr_bank_q][0] <= wr_data_i;
    else if (wr_more) mem_q[wr_bank_q][wr_cnt_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      wr_cnt_q  <= '0;
      wr_bank_q <= 1'b0;
    end else if (wr_en_i && wr_sop_i) begin
      wr_act_q <= !full_q[wr_bank_q];
      wr_cnt_q <= CNT_W'(1);
    end else if (wr_done) begin
      wr_act_q  <= 1'b0;
      wr_bank_q <= !wr_bank_q;
    end else if (wr_more) begin
      wr_cnt_q <= wr_cnt_q + CNT_W'(1);
    end
  end

  // read side
  logic             live_real, cell_end;
  logic [31:0]      hdr_w, rd_w;
  logic [BIX_W-1:0] bidx;
  logic [7:0]       raw, stored;
  logic [SCR_LEN+7:0] scr_res;

  assign live_real = (pos_q == '0) ? full_q[rd_bank_q] : real_q;
  assign cell_end  = pos_q == POS_W'(LAST_POS);
  assign bidx      = (pos_q < POS_W'(HDR_BYTES)) ? BIX_W'(pos_q) : BIX_W'(pos_q - POS_W'(1));
  assign hdr_w     = mem_q[rd_bank_q][0];
  assign rd_w      = mem_q[rd_bank_q][bidx[BIX_W-1:2]];
  assign stored    = rd_w[8*(3 - bidx[1:0]) +: 8];

  always_comb begin
    if (pos_q == POS_W'(HDR_BYTES))
      raw = hec_calc(live_real ? hdr_w : IDLE_HDR);
    else if (live_real)
      raw = stored;
    else if (pos_q < POS_W'(HDR_BYTES))
      raw = IDLE_HDR[8*(3 - pos_q[1:0]) +: 8];
    else
      raw = IDLE_FILL;
  end

  assign scr_res = scr_step(scr_q, raw);
  assign byte_o  = (pos_q > POS_W'(HDR_BYTES)) ? scr_res[7:0] : raw;
  assign sop_o   = pos_q == '0;
  assign space_o = !full_q[wr_bank_q];

  always_comb begin
    full_d = full_q;
    if (adv_i && cell_end && real_q) full_d[rd_bank_q] = 1'b0;
    if (wr_done) full_d[wr_bank_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q    <= '0;
      pos_q     <= '0;
      real_q    <= 1'b0;
      rd_bank_q <= 1'b0;
      scr_q     <= '0;
    end else begin
      full_q <= full_d;
      if (adv_i) begin
        pos_q <= cell_end ? '0 : pos_q + POS_W'(1);
        if (pos_q == '0) real_q <= full_q[rd_bank_q];
        if (cell_end && real_q) rd_bank_q <= !rd_bank_q;
        if (pos_q > POS_W'(HDR_BYTES)) scr_q <= scr_res[SCR_LEN+7:8];
      end
    end
  end

  assert_pos_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_W'(LAST_POS));
  assert_no_overwrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_act_q |-> !full_q[wr_bank_q]);
  assert_pause_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pos_q) && $stable(scr_q) && $stable(rd_bank_q));
endmodule

// File: rtl/cbm_rr_sel.sv
module cbm_rr_sel #(
  parameter int unsigned NUM = 4,
  localparam int unsigned SW = $clog2(NUM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             quad_mode_i,
  input  logic             slot_i,
  input  logic [NUM-1:0][7:0] lane_byte_i,
  input  logic [NUM-1:0]   lane_sop_i,
  output logic [NUM-1:0]   adv_o,
  output logic [7:0]       byte_o,
  output logic             sop_o,
  output logic [SW-1:0]    trib_o
);
  logic [SW-1:0] turn_q;
  logic          seen_q;

  for (genvar t = 0; t < NUM; t++) begin : g_adv
    assign adv_o[t] = slot_i && (turn_q == SW'(t));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turn_q <= '0;
      byte_o <= '0;
      sop_o  <= 1'b0;
      trib_o <= '0;
      seen_q <= 1'b0;
    end else if (slot_i) begin
      byte_o <= lane_byte_i[turn_q];
      sop_o  <= lane_sop_i[turn_q];
      trib_o <= turn_q;
      turn_q <= quad_mode_i ? turn_q + SW'(1) : '0;
      seen_q <= 1'b1;
    end
  end

  assert_rr_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_mode_i && slot_i && seen_q |=> trib_o == $past(trib_o) + SW'(1));
  assert_single_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quad_mode_i && slot_i |=> trib_o == '0);
  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(byte_o) && $stable(sop_o) && $stable(trib_o));
endmodule

// File: rtl/cell_byte_mux.sv
module cell_byte_mux
  import cbm_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 4,
  parameter int unsigned WORDS    = CELL_WORDS,
  localparam int unsigned TW      = $clog2(NUM_TRIB)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                quad_mode_i,
  input  logic                word_valid_i,
  input  logic                word_sop_i,
  input  logic [TW-1:0]       word_trib_i,
  input  logic [31:0]         word_data_i,
  output logic [NUM_TRIB-1:0] space_o,
  input  logic                slot_i,
  output logic [7:0]          byte_o,
  output logic                byte_sop_o,
  output logic [TW-1:0]       byte_trib_o
);
  logic [NUM_TRIB-1:0][7:0] lane_byte;
  logic [NUM_TRIB-1:0]      lane_sop, adv;

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_lane
    logic wr_en;
    assign wr_en = word_valid_i &&
                   (quad_mode_i ? (word_trib_i == TW'(t)) : (t == 0));
    cbm_lane #(.WORDS(WORDS)) u_lane (
      .clk_i, .rst_ni,
      .wr_en_i  (wr_en),
      .wr_sop_i (word_sop_i),
      .wr_data_i(word_data_i),
      .adv_i    (adv[t]),
      .byte_o   (lane_byte[t]),
      .sop_o    (lane_sop[t]),
      .space_o  (space_o[t])
    );
  end

  cbm_rr_sel #(.NUM(NUM_TRIB)) u_sel (
    .clk_i, .rst_ni, .quad_mode_i, .slot_i,
    .lane_byte_i(lane_byte),
    .lane_sop_i (lane_sop),
    .adv_o      (adv),
    .byte_o     (byte_o),
    .sop_o      (byte_sop_o),
    .trib_o     (byte_trib_o)
  );
endmodule

// File: tb/cell_byte_mux_bench.sv
module cell_byte_mux_bench;
  logic        clk = 1'b0, rst_ni = 1'b0, quad = 1'b0;
  logic        wv = 1'b0, wsop = 1'b0, slot = 1'b0;
  logic [1:0]  wtrib = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  space;
  logic [7:0]  bo;
  logic        bsop;
  logic [1:0]  btrib;

  always #5 clk = ~clk;

  cell_byte_mux u_cell_byte_mux (
    .clk_i(clk), .rst_ni(rst_ni), .quad_mode_i(quad),
    .word_valid_i(wv), .word_sop_i(wsop), .word_trib_i(wtrib), .word_data_i(wdata),
    .space_o(space), .slot_i(slot),
    .byte_o(bo), .byte_sop_o(bsop), .byte_trib_o(btrib)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [7:0]  qd [4][2][52];
  int          qhead [4], qcnt [4];
  logic [7:0]  wbuf [4][52];
  bit          wopen [4];
  int          widx [4];
  int          mpos [4];
  bit          mreal [4];
  logic [42:0] mscr [4];
  int          mrr;

  function automatic logic [7:0] ref_hec(input logic [7:0] h0, h1, h2, h3);
    logic [31:0] v = {h0, h1, h2, h3};
    logic [7:0]  c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      if (c[7] ^ v[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c ^ 8'h55;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      qhead[s] = 0; qcnt[s] = 0; wopen[s] = 0; widx[s] = 0;
      mpos[s] = 0; mreal[s] = 0; mscr[s] = '0;
    end
    mrr = 0;
  endtask

  task automatic do_reset(input bit q);
    @(negedge clk);
    rst_ni = 1'b0; quad = q; wv = 0; wsop = 0; slot = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(bo == 8'h00 && bsop == 0 && btrib == 0, "R9 outputs after reset", {bo, bsop, btrib}, 0);
    check(space == 4'hF, "R9 space after reset", space, 4'hF);
  endtask

  task automatic send_word(input int trib, input bit sop, input logic [31:0] d);
    int s = quad ? trib : 0;
    wv = 1; wsop = sop; wtrib = 2'(trib); wdata = d;
    @(negedge clk);
    wv = 0; wsop = 0;
    if (sop) begin
      wopen[s] = (qcnt[s] < 2);
      widx[s] = 0;
    end
    if (wopen[s]) begin
      for (int k = 0; k < 4; k++) wbuf[s][widx[s]*4+k] = d[31-8*k -: 8];
      widx[s]++;
      if (widx[s] == 13) begin
        for (int k = 0; k < 52; k++) qd[s][(qhead[s]+qcnt[s]) % 2][k] = wbuf[s][k];
        qcnt[s]++;
        wopen[s] = 0;
      end
    end
  endtask

  task automatic send_cell(input int trib);
    for (int w = 0; w < 13; w++) send_word(trib + (quad ? 0 : w % 4), w == 0, $urandom);
  endtask

  task automatic model_byte(input int s, output logic [7:0] e);
    int p = mpos[s];
    bit r = (p == 0) ? (qcnt[s] > 0) : mreal[s];
    logic [7:0] raw, h[4];
    for (int k = 0; k < 4; k++) h[k] = r ? qd[s][qhead[s]][k] : ((k == 3) ? 8'h01 : 8'h00);
    if (p < 4)       raw = h[p];
    else if (p == 4) raw = ref_hec(h[0], h[1], h[2], h[3]);
    else             raw = r ? qd[s][qhead[s]][p-1] : 8'h6A;
    e = raw;
    if (p > 4) begin
      for (int i = 7; i >= 0; i--) begin
        e[i] = raw[i] ^ mscr[s][42];
        mscr[s] = {mscr[s][41:0], e[i]};
      end
    end
    if (p == 0) mreal[s] = r;
    if (p == 52) begin
      if (mreal[s]) begin qhead[s] = 1 - qhead[s]; qcnt[s]--; end
      mpos[s] = 0;
    end else mpos[s] = p + 1;
  endtask

  task automatic run_slots(input int n);
    int given = 0;
    while (given < n) begin
      if ($urandom % 10 < 7) begin
        logic [7:0] e;
        int s = mrr;
        bit esop = (mpos[s] == 0);
        model_byte(s, e);
        slot = 1;
        @(posedge clk); #1;
        slot = 0;
        check(bo == e, quad ? "R2/R3/R6 byte quad" : "R2/R3/R1 byte single", bo, e);
        check(bsop == esop, "R2 cell start flag", bsop, esop);
        check(btrib == 2'(s), quad ? "R6 tributary order" : "R5 single source", btrib, s);
        mrr = quad ? (mrr + 1) % 4 : 0;
        given++;
        @(negedge clk);
      end else begin
        logic [7:0] pb = bo;
        logic [1:0] pt = btrib;
        @(posedge clk); #1;
        check(bo == pb && btrib == pt, "R8 hold without slot", bo, pb);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    // single mode: idle cell first (R4, R9)
    do_reset(0);
    run_slots(53);
    // R5 words with varied trib land in stream 0; R7 third cell dropped
    send_cell(0);
    send_cell(0);
    check(space[0] == 1'b0, "R7 space low with two cells", space[0], 0);
    send_cell(0);
    run_slots(40);
    send_cell(0);   // accepted or not per model (head cell still held)
    run_slots(53 * 3);
    // R10: partial cell then restart, stray words
    send_word(0, 1, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) send_word(0, 0, $urandom);
    send_cell(0);
    for (int i = 0; i < 3; i++) send_word(0, 0, $urandom);
    check(space[0] == (qcnt[0] < 2), "R10 stray words ignored", space[0], qcnt[0] < 2);
    run_slots(53 * 3 - 20);
    // directed header check: header 00 00 00 01 as data cell
    send_word(0, 1, 32'h0000_0001);
    for (int i = 0; i < 12; i++) send_word(0, 0, 32'h6A6A_6A6A);
    run_slots(53 * 2);

    // quad mode
    do_reset(1);
    send_cell(0); send_cell(0);
    send_cell(2);
    send_cell(3); send_cell(3); send_cell(3);
    check(space == 4'b0110, "R7 per-tributary space", space, 4'b0110);
    run_slots(4 * 70);
    send_cell(1); send_cell(1); send_cell(0);
    for (int i = 0; i < 6; i++) send_cell($urandom % 4);
    run_slots(4 * 53 * 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule